// File: doc/BRIEF.md
# Coprocessor Handshake Sequencer

This block runs the core side of one coprocessor instruction at a time. A pulse on `start_i` with an operation class (register write, register read, data operation, block load, block store), a byte address and a source word sends an opening phase to the coprocessor. The coprocessor answers in the same cycle, and its answer decides what follows. A busy answer leads to an idle cycle and then a retry. A refusal raises an undefined-instruction trap. An acceptance moves on to the class-specific tail: extra coprocessor and idle cycles for register moves, or a chain of word beats on the memory port for loads and stores.

While the sequencer waits out a busy answer, it polls the interrupt inputs in each idle cycle. An interrupt that passes its mask cuts the instruction short: the sequencer sends a single interrupt phase and reports the cause by priority. Loads and stores keep moving one word further, with the address stepping by four, for as long as the coprocessor answers "increment". An access outside the legal address range is refused before any handshake. A memory bus abort on any beat ends the instruction.

Top module: `cp_handshake_seq`

## Requirements
- R1: In idle, `start_i` is accepted. In the next cycle `cp_valid_o` is high with the opening phase (phase code 0). Every instruction ends with exactly one one-cycle end pulse among `done_o`, `undef_o`, `intr_o`, `fault_o` and `dabort_o`, and the pulse appears in the cycle after the last active state.
- R2: A busy answer (response code 1) to the opening or a retry phase gives one cycle with `idle_o` high and `cp_valid_o` low, then a retry phase (code 1). Each busy answer therefore adds two cycles.
- R3: If an unmasked interrupt is pending during a busy idle cycle, the next cycle sends the interrupt phase (code 2) once. The cycle after that raises `intr_o`, and no further phase or memory access follows.
- R4: `intr_cause_o` follows the priority reset request (0), then fast interrupt (1) if its mask is clear, then normal interrupt (2) if its mask is clear. A masked request has no effect, and the busy retry continues.
- R5: A refusal (response code 2) raises `undef_o`. For a register read, `rd_data_o` then holds `flags_i` in its top four bits and zeros below.
- R6: An accepted register write (op code 0), whose source word is on `cp_data_o` during the opening phase, takes one cycle with `cop_o` high and then ends with `done_o`.
- R7: An accepted register read (op code 1) captures `cp_data_i` from the accepting cycle into `rd_data_o`. It then spends one `cop_o` cycle and one `idle_o` cycle before `done_o`.
- R8: An accepted data operation (op code 2) ends with `done_o` in the next cycle.
- R9: A load (op code 3) sends the transfer phase (code 3) while it reads the word at the base address. It then delivers that word on `cp_data_o` with the data phase (code 4). Each increment answer (code 3) adds 4 to the address and reads and delivers the next word. Any other answer ends the load.
- R10: A store (op code 4) writes `cp_data_i` to memory on every data-phase cycle. An increment answer adds 4 to the address for the next beat; any other answer ends the store.
- R11: A load at or above `ADDR_LIMIT`, or a store at or above `ADDR_LIMIT` or below `VEC_END`, raises `fault_o` in the next cycle. No phase and no memory access take place.
- R12: `mem_abort_i` during any memory beat ends the instruction, and `dabort_o` pulses in the next cycle. No phase follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an instruction (sampled in idle) |
| op_i | input | 3 | Operation class code |
| addr_i | input | AW | Byte base address for load/store |
| wdata_i | input | DW | Source word for a register write |
| flags_i | input | 4 | Condition-code bits |
| rst_req_i | input | 1 | Reset request |
| fiq_i | input | 1 | Fast interrupt request |
| fiq_mask_i | input | 1 | Fast interrupt mask |
| irq_i | input | 1 | Normal interrupt request |
| irq_mask_i | input | 1 | Normal interrupt mask |
| cp_valid_o | output | 1 | Phase is being presented |
| cp_phase_o | output | 3 | Phase code |
| cp_data_o | output | DW | Word to the coprocessor |
| cp_resp_i | input | 2 | Coprocessor response code |
| cp_data_i | input | DW | Word from the coprocessor |
| mem_req_o | output | 1 | Memory beat |
| mem_we_o | output | 1 | Beat is a write |
| mem_addr_o | output | AW | Beat byte address |
| mem_wdata_o | output | DW | Write data |
| mem_rdata_i | input | DW | Read data, same cycle |
| mem_abort_i | input | 1 | Bus abort on this beat |
| idle_o | output | 1 | Idle cycle |
| cop_o | output | 1 | Coprocessor cycle |
| done_o | output | 1 | Completed pulse |
| undef_o | output | 1 | Undefined-instruction trap pulse |
| intr_o | output | 1 | Abandoned for interrupt pulse |
| intr_cause_o | output | 2 | Interrupt cause |
| fault_o | output | 1 | Address refused pulse |
| dabort_o | output | 1 | Data abort pulse |
| rd_data_o | output | DW | Register read result |

## Verification
The properties assume that the coprocessor response and the memory read data and abort are valid in the same cycle as the request and stay stable until the clock edge. They also assume that `start_i` is raised only while no instruction is in progress. The bench plays a combinational coprocessor and memory that change their inputs only at the falling edge, from a response script set up per instruction. It waits for the end pulse before it issues the next start, and it holds the interrupt and mask inputs steady across each instruction.

// File: rtl/cp_seq_pkg.sv
package cp_seq_pkg;
  typedef enum logic [2:0] {PH_FIRST = 3'd0, PH_BUSY = 3'd1, PH_INTR = 3'd2,
                            PH_XFER = 3'd3, PH_DATA = 3'd4} phase_e;
  typedef enum logic [1:0] {RS_DONE = 2'd0, RS_BUSY = 2'd1, RS_CANT = 2'd2,
                            RS_INC = 2'd3} resp_e;
  typedef enum logic [2:0] {OP_WR = 3'd0, OP_RD = 3'd1, OP_DOP = 3'd2,
                            OP_LD = 3'd3, OP_ST = 3'd4} op_e;
  typedef enum logic [1:0] {CS_RESET = 2'd0, CS_FIQ = 2'd1, CS_IRQ = 2'd2} cause_e;
  typedef enum logic [3:0] {S_IDLE, S_ASK, S_WAIT, S_INTR, S_CCYC, S_ICYC,
                            S_XFER, S_LDATA, S_LREAD, S_SDATA} state_e;
endpackage

// File: rtl/cp_seq_intr_arb.sv
module cp_seq_intr_arb
  import cp_seq_pkg::*;
(
  input  logic       rst_req_i,
  input  logic       fiq_i,
  input  logic       fiq_mask_i,
  input  logic       irq_i,
  input  logic       irq_mask_i,
  output logic       pend_o,
  output logic [1:0] cause_o
);
  logic fiq_live, irq_live;
  assign fiq_live = fiq_i & ~fiq_mask_i;
  assign irq_live = irq_i & ~irq_mask_i;
  assign pend_o   = rst_req_i | fiq_live | irq_live;

  always_comb begin
    if (rst_req_i)     cause_o = CS_RESET;
    else if (fiq_live) cause_o = CS_FIQ;
    else               cause_o = CS_IRQ;
  end
endmodule

// File: rtl/cp_seq_addr_chk.sv
module cp_seq_addr_chk #(
  parameter int unsigned     AW         = 32,
  parameter logic [AW-1:0]   ADDR_LIMIT = 32'h0400_0000,
  parameter logic [AW-1:0]   VEC_END    = 32'h0000_0020
) (
  input  logic [AW-1:0] addr_i,
  input  logic          is_ld_i,
  input  logic          is_st_i,
  output logic          bad_o
);
  logic over, in_vec;
  assign over   = addr_i >= ADDR_LIMIT;
  assign in_vec = addr_i < VEC_END;
  // stores also refuse the vector region
  assign bad_o  = (is_ld_i & over) | (is_st_i & (over | in_vec));
endmodule

// File: rtl/cp_seq_addr_step.sv
module cp_seq_addr_step #(
  parameter int unsigned AW   = 32,
  parameter int unsigned STEP = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] base_i,
  input  logic          inc_i,
  output logic [AW-1:0] addr_o
);
  localparam logic [AW-1:0] StepW = AW'(STEP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_o <= '0;
    else if (load_i) addr_o <= base_i;
    else if (inc_i)  addr_o <= addr_o + StepW;
  end
endmodule

// File: rtl/cp_handshake_seq.sv
module cp_handshake_seq
  import cp_seq_pkg::*;
#(
  parameter int unsigned   DW         = 32,
  parameter int unsigned   AW         = 32,
  parameter logic [AW-1:0] ADDR_LIMIT = 32'h0400_0000,
  parameter logic [AW-1:0] VEC_END    = 32'h0000_0020
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [2:0]    op_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [3:0]    flags_i,
  input  logic          rst_req_i,
  input  logic          fiq_i,
  input  logic          fiq_mask_i,
  input  logic          irq_i,
  input  logic          irq_mask_i,
  output logic          cp_valid_o,
  output logic [2:0]    cp_phase_o,
  output logic [DW-1:0] cp_data_o,
  input  logic [1:0]    cp_resp_i,
  input  logic [DW-1:0] cp_data_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          mem_abort_i,
  output logic          idle_o,
  output logic          cop_o,
  output logic          done_o,
  output logic          undef_o,
  output logic          intr_o,
  output logic [1:0]    intr_cause_o,
  output logic          fault_o,
  output logic          dabort_o,
  output logic [DW-1:0] rd_data_o
);
  localparam int unsigned FlagW = 4;

  state_e        st_q, st_d;
  logic [2:0]    op_q;
  logic [DW-1:0] src_q, word_q;
  logic          retry_q, retry_d;
  logic          pend;
  logic [1:0]    cause;
  logic          bad;
  logic          ld_base, step, take_word, cap_rd, cap_flags;
  logic          e_done, e_undef, e_intr, e_fault, e_dab;

  cp_seq_intr_arb u_arb (
    .rst_req_i (rst_req_i), .fiq_i (fiq_i), .fiq_mask_i (fiq_mask_i),
    .irq_i (irq_i), .irq_mask_i (irq_mask_i), .pend_o (pend), .cause_o (cause)
  );

  cp_seq_addr_chk #(.AW(AW), .ADDR_LIMIT(ADDR_LIMIT), .VEC_END(VEC_END)) u_chk (
    .addr_i (addr_i), .is_ld_i (op_i == OP_LD), .is_st_i (op_i == OP_ST), .bad_o (bad)
  );

  cp_seq_addr_step #(.AW(AW), .STEP(4)) u_step (
    .clk_i (clk_i), .rst_ni (rst_ni), .load_i (ld_base), .base_i (addr_i),
    .inc_i (step), .addr_o (mem_addr_o)
  );

  always_comb begin
    st_d = st_q; retry_d = retry_q;
    ld_base = 1'b0; step = 1'b0; take_word = 1'b0; cap_rd = 1'b0; cap_flags = 1'b0;
    e_done = 1'b0; e_undef = 1'b0; e_intr = 1'b0; e_fault = 1'b0; e_dab = 1'b0;
    unique case (st_q)
      S_IDLE: if (start_i) begin
        ld_base = 1'b1;
        if (bad) e_fault = 1'b1;
        else begin st_d = S_ASK; retry_d = 1'b0; end
      end
      S_ASK: unique case (cp_resp_i)
        RS_BUSY: st_d = S_WAIT;
        RS_CANT: begin st_d = S_IDLE; e_undef = 1'b1; cap_flags = (op_q == OP_RD); end
        default: begin
          cap_rd = (op_q == OP_RD);
          unique case (op_q)
            OP_WR, OP_RD: st_d = S_CCYC;
            OP_LD:        st_d = S_XFER;
            OP_ST:        st_d = S_SDATA;
            default:      begin st_d = S_IDLE; e_done = 1'b1; end
          endcase
        end
      endcase
      S_WAIT: if (pend) st_d = S_INTR;
              else begin st_d = S_ASK; retry_d = 1'b1; end
      S_INTR: begin st_d = S_IDLE; e_intr = 1'b1; end
      S_CCYC: if (op_q == OP_RD) st_d = S_ICYC;
              else begin st_d = S_IDLE; e_done = 1'b1; end
      S_ICYC: begin st_d = S_IDLE; e_done = 1'b1; end
      S_XFER, S_LREAD: begin
        take_word = 1'b1;
        if (mem_abort_i) begin st_d = S_IDLE; e_dab = 1'b1; end
        else st_d = S_LDATA;
      end
      S_LDATA: if (cp_resp_i == RS_INC) begin step = 1'b1; st_d = S_LREAD; end
               else begin st_d = S_IDLE; e_done = 1'b1; end
      S_SDATA: if (mem_abort_i) begin st_d = S_IDLE; e_dab = 1'b1; end
               else if (cp_resp_i == RS_INC) step = 1'b1;
               else begin st_d = S_IDLE; e_done = 1'b1; end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE; retry_q <= 1'b0; op_q <= '0; src_q <= '0; word_q <= '0;
      rd_data_o <= '0; intr_cause_o <= '0;
      done_o <= 1'b0; undef_o <= 1'b0; intr_o <= 1'b0; fault_o <= 1'b0; dabort_o <= 1'b0;
    end else begin
      st_q <= st_d; retry_q <= retry_d;
      done_o <= e_done; undef_o <= e_undef; intr_o <= e_intr;
      fault_o <= e_fault; dabort_o <= e_dab;
      if (ld_base) begin op_q <= op_i; src_q <= wdata_i; end
      if (take_word) word_q <= mem_rdata_i;
      if (cap_rd) rd_data_o <= cp_data_i;
      if (cap_flags) rd_data_o <= {flags_i, {(DW-FlagW){1'b0}}};
      if (st_q == S_WAIT && pend) intr_cause_o <= cause;
    end
  end

  always_comb begin
    cp_valid_o = 1'b1;
    cp_phase_o = PH_DATA;
    unique case (st_q)
      S_ASK:           cp_phase_o = retry_q ? PH_BUSY : PH_FIRST;
      S_INTR:          cp_phase_o = PH_INTR;
      S_XFER:          cp_phase_o = PH_XFER;
      S_LDATA, S_SDATA: cp_phase_o = PH_DATA;
      default:         cp_valid_o = 1'b0;
    endcase
  end

  assign cp_data_o   = (st_q == S_LDATA) ? word_q : src_q;
  assign mem_req_o   = (st_q == S_XFER) || (st_q == S_LREAD) || (st_q == S_SDATA);
  assign mem_we_o    = (st_q == S_SDATA);
  assign mem_wdata_o = cp_data_i;
  assign idle_o      = (st_q == S_WAIT) || (st_q == S_ICYC);
  assign cop_o       = (st_q == S_CCYC);
endmodule

// File: rtl/cp_seq_chk.sv
module cp_seq_chk
  import cp_seq_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cp_valid_o,
  input logic [2:0]    cp_phase_o,
  input logic [1:0]    cp_resp_i,
  input logic          idle_o,
  input logic          done_o,
  input logic          undef_o,
  input logic          intr_o,
  input logic          fault_o,
  input logic          dabort_o,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic          mem_abort_i,
  input logic [AW-1:0] mem_addr_o
);
  logic asking;
  assign asking = cp_valid_o && (cp_phase_o == PH_FIRST || cp_phase_o == PH_BUSY);

  p_one_end_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, undef_o, intr_o, fault_o, dabort_o}));

  p_busy_idles_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    asking && cp_resp_i == RS_BUSY |=> idle_o && !cp_valid_o);

  p_retry_after_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cp_valid_o && cp_phase_o == PH_BUSY |-> $past(idle_o));

  p_intr_ends_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cp_valid_o && cp_phase_o == PH_INTR |=> intr_o && !cp_valid_o && !mem_req_o);

  p_cant_traps_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    asking && cp_resp_i == RS_CANT |=> undef_o);

  p_store_step_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o && !mem_abort_i && cp_resp_i == RS_INC
    |=> mem_req_o && mem_addr_o == $past(mem_addr_o) + AW'(4));

  p_abort_stops_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_abort_i |=> dabort_o && !cp_valid_o && !mem_req_o);
endmodule

bind cp_handshake_seq cp_seq_chk #(.AW(AW)) u_sva (
  .clk_i (clk_i), .rst_ni (rst_ni), .cp_valid_o (cp_valid_o), .cp_phase_o (cp_phase_o),
  .cp_resp_i (cp_resp_i), .idle_o (idle_o), .done_o (done_o), .undef_o (undef_o),
  .intr_o (intr_o), .fault_o (fault_o), .dabort_o (dabort_o), .mem_req_o (mem_req_o),
  .mem_we_o (mem_we_o), .mem_abort_i (mem_abort_i), .mem_addr_o (mem_addr_o)
);

// File: tb/sim_cp_handshake_seq.sv
module sim_cp_handshake_seq;
  localparam logic [31:0] LIM = 32'h0400_0000;
  localparam logic [31:0] VEC = 32'h0000_0020;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [2:0] op_i = '0;
  logic [31:0] addr_i = '0, wdata_i = '0;
  logic [3:0] flags_i = '0;
  logic rst_req_i = 1'b0, fiq_i = 1'b0, fiq_mask_i = 1'b0, irq_i = 1'b0, irq_mask_i = 1'b0;
  logic cp_valid_o; logic [2:0] cp_phase_o; logic [31:0] cp_data_o;
  logic [1:0] cp_resp_i = '0; logic [31:0] cp_data_i = '0;
  logic mem_req_o, mem_we_o; logic [31:0] mem_addr_o, mem_wdata_o;
  logic [31:0] mem_rdata_i = '0; logic mem_abort_i = 1'b0;
  logic idle_o, cop_o, done_o, undef_o, intr_o, fault_o, dabort_o;
  logic [1:0] intr_cause_o; logic [31:0] rd_data_o;

  always #10 clk_i = ~clk_i;

  cp_handshake_seq u0 (.*);

  int n_chk = 0, n_bad = 0;
  logic [1:0]  resp_s [0:63];
  logic [31:0] cpd_s  [0:63];
  logic [2:0]  ph_log [0:63];
  logic [31:0] cpo_log[0:63];
  logic [31:0] ma_log [0:63], mw_log[0:63];
  logic        mwe_log[0:63];
  int ptr = 0, nhs = 0, nmem = 0, idle_cnt = 0, cop_cnt = 0, abort_beat = 99, salt = 0;

  function automatic logic [31:0] mem_fn(logic [31:0] a);
    return {a[15:0] ^ 16'h5A3C, ~a[15:0]};
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // coprocessor and memory model, changes only at the falling edge
  initial forever begin
    @(negedge clk_i);
    cp_resp_i   = resp_s[ptr];
    cp_data_i   = cpd_s[ptr];
    mem_rdata_i = mem_fn(mem_addr_o);
    mem_abort_i = mem_req_o && (nmem == abort_beat);
    #1;
    if (idle_o) idle_cnt++;
    if (cop_o) cop_cnt++;
    if (cp_valid_o && nhs < 64) begin
      ph_log[nhs] = cp_phase_o; cpo_log[nhs] = cp_data_o; nhs++; ptr++;
    end
    if (mem_req_o && nmem < 64) begin
      ma_log[nmem] = mem_addr_o; mw_log[nmem] = mem_wdata_o; mwe_log[nmem] = mem_we_o; nmem++;
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_bad++; n_chk++;
    $display("FAIL R1 watchdog: actual 1 expected 0");
    summary();
    $finish;
  end

  // kind: 0 done 1 undef 2 intr 3 fault 4 dabort
  task automatic run(input logic [2:0] op, input logic [31:0] a, input int nb,
                     input logic [1:0] fin, input int ninc, input int ab);
    int lat, kind, ek, elat, ehs, emem, eidle, ecop, dh, k, slot;
    bit pend, fault, ok;
    logic [1:0] ecause;
    logic [31:0] wd;
    salt++;
    for (int i = 0; i < 64; i++) begin
      resp_s[i] = 2'd0; cpd_s[i] = 32'hD000_0000 + i * 32'h111 + salt;
    end
    for (int i = 0; i < nb; i++) resp_s[i] = 2'd1;
    resp_s[nb] = fin;
    if (op == 3'd3) for (int i = 0; i < ninc; i++) resp_s[nb + 2 + i] = 2'd3;
    if (op == 3'd4) for (int i = 0; i < ninc; i++) resp_s[nb + 1 + i] = 2'd3;
    @(negedge clk_i);
    abort_beat = ab; ptr = 0; nhs = 0; nmem = 0; idle_cnt = 0; cop_cnt = 0;
    wd = $urandom;
    op_i = op; addr_i = a; wdata_i = wd; start_i = 1'b1;
    lat = 0; kind = -1;
    while (kind < 0 && lat < 300) begin
      @(negedge clk_i);
      start_i = 1'b0;
      lat++;
      if (done_o) kind = 0; else if (undef_o) kind = 1; else if (intr_o) kind = 2;
      else if (fault_o) kind = 3; else if (dabort_o) kind = 4;
    end
    #2;
    // expected model
    pend  = rst_req_i | (fiq_i & ~fiq_mask_i) | (irq_i & ~irq_mask_i);
    ecause = rst_req_i ? 2'd0 : (fiq_i & ~fiq_mask_i) ? 2'd1 : 2'd2;
    fault = (op == 3'd3 && a >= LIM) || (op == 3'd4 && (a >= LIM || a < VEC));
    emem = 0; eidle = nb; ecop = 0; dh = 0;
    if (fault) begin ek = 3; elat = 1; ehs = 0; eidle = 0; end
    else if (nb > 0 && pend) begin ek = 2; elat = 4; ehs = 2; eidle = 1; end
    else if (fin == 2'd2) begin ek = 1; elat = 2 * nb + 2; ehs = nb + 1; end
    else begin
      ek = 0; ehs = nb + 1;
      case (op)
        3'd0: begin elat = 2 * nb + 3; ecop = 1; end
        3'd1: begin elat = 2 * nb + 4; ecop = 1; eidle = nb + 1; end
        3'd3: begin
          if (ab <= ninc) begin ek = 4; emem = ab + 1; dh = ab; elat = 2 * nb + 3 + 2 * ab; end
          else begin emem = ninc + 1; dh = ninc + 1; elat = 2 * nb + 4 + 2 * ninc; end
          ehs = nb + 2 + dh;
        end
        3'd4: begin
          if (ab <= ninc) begin ek = 4; emem = ab + 1; elat = 2 * nb + 3 + ab; end
          else begin emem = ninc + 1; elat = 2 * nb + 3 + ninc; end
          ehs = nb + 1 + emem;
        end
        default: elat = 2 * nb + 2;
      endcase
    end
    chk(kind == ek, (ek == 3) ? "R11" : (ek == 4) ? "R12" : (ek == 2) ? "R3" :
        (ek == 1) ? "R5" : "R1", "end kind", kind, ek);
    chk(lat == elat, (nb > 0) ? "R2" : "R1", "latency", lat, elat);
    chk(nhs == ehs, (ek == 3) ? "R11" : "R1", "handshakes", nhs, ehs);
    chk(nmem == emem, (ek == 3) ? "R11" : (op == 3'd4) ? "R10" : "R9", "mem beats", nmem, emem);
    chk(idle_cnt == eidle, (op == 3'd1 && ek == 0) ? "R7" : "R2", "idle cycles", idle_cnt, eidle);
    chk(cop_cnt == ecop, (op == 3'd1) ? "R7" : "R6", "cop cycles", cop_cnt, ecop);
    // phase sequence
    ok = 1'b1;
    for (int i = 0; i < nhs && i < ehs; i++) begin
      logic [2:0] ep;
      if (i == 0) ep = 3'd0;
      else if (ek == 2) ep = 3'd2;
      else if (i <= nb) ep = 3'd1;
      else if (op == 3'd3 && i == nb + 1) ep = 3'd3;
      else ep = 3'd4;
      if (ph_log[i] != ep) ok = 1'b0;
    end
    chk(ok, (ek == 2) ? "R3" : (op == 3'd3) ? "R9" : "R2", "phase sequence", ok, 1);
    if (ek == 2) chk(intr_cause_o == ecause, "R4", "cause", intr_cause_o, ecause);
    if (!fault && nhs > 0 && op == 3'd0)
      chk(cpo_log[0] == wd, "R6", "source word", cpo_log[0], wd);
    if (op == 3'd1 && ek == 0)
      chk(rd_data_o == cpd_s[nb], "R7", "read result", rd_data_o, cpd_s[nb]);
    if (op == 3'd1 && ek == 1)
      chk(rd_data_o == {flags_i, 28'h0}, "R5", "refused read", rd_data_o, {flags_i, 28'h0});
    if (op == 3'd3 && !fault && ek != 2 && ek != 1) begin
      ok = 1'b1;
      for (k = 0; k < emem && k < nmem; k++)
        if (ma_log[k] != a + 4 * k || mwe_log[k]) ok = 1'b0;
      for (k = 0; k < dh && nb + 2 + k < nhs; k++)
        if (cpo_log[nb + 2 + k] != mem_fn(a + 4 * k)) ok = 1'b0;
      chk(ok, "R9", "load words", ok, 1);
    end
    if (op == 3'd4 && !fault && ek != 2 && ek != 1) begin
      ok = 1'b1;
      for (k = 0; k < emem && k < nmem; k++) begin
        slot = nb + 1 + k;
        if (ma_log[k] != a + 4 * k || !mwe_log[k] || mw_log[k] != cpd_s[slot]) ok = 1'b0;
      end
      chk(ok, "R10", "store words", ok, 1);
    end
  endtask

  task automatic set_int(bit r, bit f, bit fm, bit i, bit im);
    rst_req_i = r; fiq_i = f; fiq_mask_i = fm; irq_i = i; irq_mask_i = im;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin resp_s[i] = 2'd0; cpd_s[i] = '0; end
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    chk(!cp_valid_o && !mem_req_o && !done_o && !idle_o, "R1", "reset outputs",
        {cp_valid_o, mem_req_o, done_o, idle_o}, 0);
    rst_ni = 1'b1;
    flags_i = 4'b1010;
    // directed cases
    run(3'd0, 32'h100, 0, 2'd0, 0, 99);   // R6 register write
    run(3'd1, 32'h100, 0, 2'd0, 0, 99);   // R7 register read
    run(3'd1, 32'h100, 2, 2'd2, 0, 99);   // R5 refused read after busy
    run(3'd2, 32'h100, 0, 2'd0, 0, 99);   // R8 data op
    run(3'd2, 32'h100, 3, 2'd0, 0, 99);   // R2 three busy answers
    run(3'd3, 32'h200, 1, 2'd0, 3, 99);   // R9 load four words
    run(3'd4, 32'h300, 0, 2'd0, 2, 99);   // R10 store three words
    run(3'd4, 32'h10, 0, 2'd0, 0, 99);    // R11 store into vector region
    run(3'd3, 32'h10, 0, 2'd0, 0, 99);    // R11 load below vectors is legal
    run(3'd3, LIM, 0, 2'd0, 0, 99);       // R11 load out of range
    run(3'd3, 32'h400, 0, 2'd0, 3, 2);    // R12 abort on third load beat
    run(3'd4, 32'h400, 0, 2'd0, 3, 0);    // R12 abort on first store beat
    set_int(1, 1, 0, 1, 0); run(3'd2, 32'h100, 2, 2'd0, 0, 99); // R4 reset wins
    set_int(0, 1, 0, 1, 0); run(3'd3, 32'h100, 1, 2'd0, 0, 99); // R4 fiq
    set_int(0, 1, 1, 1, 0); run(3'd0, 32'h100, 1, 2'd0, 0, 99); // R4 irq, fiq masked
    set_int(0, 1, 1, 1, 1); run(3'd1, 32'h100, 2, 2'd0, 0, 99); // R4 all masked
    set_int(0, 0, 0, 1, 0); run(3'd1, 32'h100, 0, 2'd0, 0, 99); // R3 no busy, no poll
    set_int(0, 0, 0, 0, 0);
    // constrained random
    for (int t = 0; t < 80; t++) begin
      logic [2:0] op; logic [31:0] a; logic [1:0] fin; int ab;
      op  = 3'($urandom_range(0, 4));
      a   = ($urandom_range(0, 9) == 0) ? LIM + ($urandom_range(0, 255) << 2)
                                        : 32'($urandom_range(0, 4095)) << 2;
      fin = ($urandom_range(0, 4) == 0) ? 2'd2 : (($urandom_range(0, 1) == 1) ? 2'd3 : 2'd0);
      ab  = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 3) : 99;
      flags_i = 4'($urandom);
      set_int(($urandom_range(0, 15) == 0), ($urandom_range(0, 5) == 0), $urandom_range(0, 1) == 1,
              ($urandom_range(0, 5) == 0), $urandom_range(0, 1) == 1);
      run(op, a, $urandom_range(0, 3), fin, $urandom_range(0, 3), ab);
    end
    summary();
    $finish;
  end
endmodule